// File: doc/BRIEF.md
# Split Analog/Digital Gain Controller

This block turns one 16-bit gain-control word into three coordinated settings: a flag that engages a fixed 16 dB front-end attenuator, a 14-bit code for a 12 dB analog attenuation stage, and a fixed-point factor for a digital gain stage. The digital stage multiplies the 16-bit signed I and Q samples that leave a decimation filter by that factor. It rounds each product and clamps it to the 16-bit range.

The word reaches the block in one of two ways. In manual mode, software writes it, and a limiter makes sure the active word changes no more often than once per 240 clock cycles. A write that comes too early waits until the interval is over. In automatic mode, an external control loop supplies the word on every cycle. Bit 15 of the word drives only the front-end flag. Bits 14..0 form an attenuation field. With the digital stage enabled, the full 15-bit field spans −12 dB to +12 dB. The lower half of the field uses digital gain and the upper half uses analog attenuation. With the digital stage disabled, only bits 13..0 are used, and all of the 0 to 12 dB is analog.

Top module: `gain_split_ctrl`

## Requirements
- R1: While `rst` is high, `fe_atten` = 0, `ana_code` = 0, `dig_factor` = 8192 (unity), `out_valid` = 0, and `out_i` = `out_q` = 0.
- R2: `fe_atten` equals bit 15 of the active word, whatever the other bits are and whatever `dgain_en` is.
- R3: With `dgain_en` = 0, `ana_code` = word[13:0] and `dig_factor` = 8192. Bit 14 has no effect.
- R4: With `dgain_en` = 1 and field = word[14:0] ≥ 0x4000, `ana_code` = field − 0x4000 and `dig_factor` = 8192.
- R5: With `dgain_en` = 1 and field < 0x4000, `ana_code` = 0. Let g = 0x4000 − field. Then `dig_factor` = (8192 + (g mod 8192)) · 2^(g div 8192). This is an unsigned value with 13 fraction bits, ranging from 1.0 to 4.0. Field 0 gives 32768.
- R6: A sample pair taken when `smp_valid` = 1 appears one clock later with `out_valid` = 1. Each lane equals floor((s·f + 4096)/8192), clamped to [−32768, 32767], where f is the `dig_factor` present when the sample is taken. `out_valid` is 0 on any cycle after a clock where `smp_valid` was 0.
- R7: In manual mode (`mode_auto` = 0), a write on `wr_valid` becomes the active word at that edge when the limiter is idle. The gain outputs show its decoding one edge later. Two applied words are never less than 240 clocks apart.
- R8: In manual mode, a write that arrives before 240 clocks have passed since the last applied word is held. Only the newest held write is kept. It becomes active exactly 240 clocks after the previous one.
- R9: In automatic mode, `auto_word` becomes the active word on every edge and the gain outputs follow one edge later. Writes are ignored, and any held write is discarded, so it is not applied after a return to manual mode.
- R10: `fe_atten`, `ana_code` and `dig_factor` change on the same edge. `ana_code` is never nonzero while `dig_factor` differs from unity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_auto | input | 1 | 0 = manual (register writes), 1 = automatic (external loop) |
| dgain_en | input | 1 | 1 enables the digital gain stage |
| wr_valid | input | 1 | Register write strobe for the gain word |
| wr_word | input | 16 | Gain word written by software |
| auto_word | input | 16 | Gain word from the automatic loop |
| smp_valid | input | 1 | Input sample pair valid |
| smp_i | input | 16 | Signed I sample from the decimation filter |
| smp_q | input | 16 | Signed Q sample from the decimation filter |
| fe_atten | output | 1 | Fixed 16 dB front-end attenuator enable |
| ana_code | output | 14 | Analog attenuation code, 0 to 12 dB, linear |
| dig_factor | output | 16 | Digital gain factor, unsigned with 13 fraction bits |
| out_valid | output | 1 | Scaled sample pair valid |
| out_i | output | 16 | Scaled, rounded, saturated I sample |
| out_q | output | 16 | Scaled, rounded, saturated Q sample |

## Verification
The hold-stability property assumes that `dgain_en` and `mode_auto` change only when the designer intends a new setting. Because of this, it is conditioned on two quiet cycles with no applied word, no automatic mode and a constant enable. The bench changes `dgain_en` only between scenarios, and it drives samples only after the gain word has settled. The sign property assumes the factor is always positive, which the decoder guarantees for every word. The bench's 16-bit samples reach both clamps with factor 4.0 and otherwise stay in range.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  // Source selection for the active gain word
  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_AUTO   = 1'b1
  } gsc_mode_e;

  localparam int GSC_DEF_WORD_W   = 16;
  localparam int GSC_DEF_SMP_W    = 16;
  localparam int GSC_DEF_INTERVAL = 240;
endpackage

// File: rtl/gsc_rate_limiter.sv
module gsc_rate_limiter #(
  parameter int WORD_W   = 16,
  parameter int INTERVAL = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_mode,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [WORD_W-1:0] auto_word,
  output logic [WORD_W-1:0] cur_word,
  output logic              apply
);
  localparam int CNT_W = $clog2(INTERVAL + 1);

  logic [CNT_W-1:0]  wait_q;
  logic              held_v;
  logic [WORD_W-1:0] held_w;
  logic              idle;
  logic [WORD_W-1:0] next_w;

  assign idle   = (wait_q == '0);
  assign apply  = !auto_mode && idle && (wr_valid || held_v);
  assign next_w = wr_valid ? wr_word : held_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q   <= '0;
      held_v   <= 1'b0;
      held_w   <= '0;
      cur_word <= '0;
    end else if (auto_mode) begin
      cur_word <= auto_word;
      held_v   <= 1'b0;
      if (!idle) wait_q <= wait_q - 1'b1;
    end else if (apply) begin
      cur_word <= next_w;
      held_v   <= 1'b0;
      wait_q   <= CNT_W'(INTERVAL - 1);
    end else begin
      if (!idle) wait_q <= wait_q - 1'b1;
      if (wr_valid) begin
        held_w <= wr_word;
        held_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gsc_gain_decoder.sv
module gsc_gain_decoder #(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dgain_en,
  input  logic [WORD_W-1:0]   word,
  output logic                fe_atten,
  output logic [WORD_W-3:0]   ana_code,
  output logic [WORD_W-1:0]   dig_factor
);
  localparam int ANA_W  = WORD_W - 2;
  localparam int FLD_W  = WORD_W - 1;
  localparam int FRAC_W = WORD_W - 3;
  localparam int FACT_W = WORD_W;
  localparam logic [FLD_W-1:0]  MID   = FLD_W'(1) << ANA_W;
  localparam logic [FACT_W-1:0] UNITY = FACT_W'(1) << FRAC_W;

  logic [FLD_W-1:0]  field;
  logic [FLD_W-1:0]  below;
  logic [1:0]        octave;
  logic [FRAC_W:0]   mant;
  logic [FACT_W:0]   fac_wide;
  logic [ANA_W-1:0]  ana_n;
  logic [FACT_W-1:0] fac_n;

  // Piecewise-linear exponent: octave picks the shift, the rest interpolates
  assign field    = word[FLD_W-1:0];
  assign below    = MID - field;
  assign octave   = below[FLD_W-1:FRAC_W];
  assign mant     = {1'b1, below[FRAC_W-1:0]};
  assign fac_wide = (FACT_W+1)'(mant) << octave;

  always_comb begin
    if (!dgain_en) begin
      ana_n = word[ANA_W-1:0];
      fac_n = UNITY;
    end else if (field[FLD_W-1]) begin
      ana_n = field[ANA_W-1:0];
      fac_n = UNITY;
    end else begin
      ana_n = '0;
      fac_n = fac_wide[FACT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fe_atten   <= 1'b0;
      ana_code   <= '0;
      dig_factor <= UNITY;
    end else begin
      fe_atten   <= word[WORD_W-1];
      ana_code   <= ana_n;
      dig_factor <= fac_n;
    end
  end
endmodule

// File: rtl/gsc_lane_scaler.sv
module gsc_lane_scaler #(
  parameter int SMP_W  = 16,
  parameter int FACT_W = 16,
  parameter int FRAC_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SMP_W-1:0] smp,
  input  logic [FACT_W-1:0] fac,
  output logic [SMP_W-1:0] res
);
  localparam int PROD_W = SMP_W + FACT_W + 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] MAXV = (PROD_W'(1) << (SMP_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rnd;
  logic signed [PROD_W-1:0] shf;
  logic        [SMP_W-1:0]  sat;

  assign prod = $signed(smp) * $signed({1'b0, fac});
  assign rnd  = prod + HALF;
  assign shf  = rnd >>> FRAC_W;

  always_comb begin
    if (shf > MAXV)      sat = MAXV[SMP_W-1:0];
    else if (shf < MINV) sat = MINV[SMP_W-1:0];
    else                 sat = shf[SMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     res <= '0;
    else if (en) res <= sat;
  end
endmodule

// File: rtl/gain_split_ctrl.sv
module gain_split_ctrl
  import gsc_pkg::*;
#(
  parameter int WORD_W   = GSC_DEF_WORD_W,
  parameter int SMP_W    = GSC_DEF_SMP_W,
  parameter int INTERVAL = GSC_DEF_INTERVAL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_auto,
  input  logic              dgain_en,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [WORD_W-1:0] auto_word,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [SMP_W-1:0]  smp_q,
  output logic              fe_atten,
  output logic [WORD_W-3:0] ana_code,
  output logic [WORD_W-1:0] dig_factor,
  output logic              out_valid,
  output logic [SMP_W-1:0]  out_i,
  output logic [SMP_W-1:0]  out_q
);
  localparam int FRAC_W = WORD_W - 3;
  localparam int FACT_W = WORD_W;
  localparam int LANES  = 2;

  gsc_mode_e         mode;
  logic [WORD_W-1:0] active_word;
  logic              apply_w;
  logic [SMP_W-1:0]  lane_in  [LANES];
  logic [SMP_W-1:0]  lane_out [LANES];

  assign mode = gsc_mode_e'(mode_auto);

  gsc_rate_limiter #(.WORD_W(WORD_W), .INTERVAL(INTERVAL)) u_limit (
    .clk       (clk),
    .rst       (rst),
    .auto_mode (mode == MODE_AUTO),
    .wr_valid  (wr_valid),
    .wr_word   (wr_word),
    .auto_word (auto_word),
    .cur_word  (active_word),
    .apply     (apply_w)
  );

  gsc_gain_decoder #(.WORD_W(WORD_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .dgain_en   (dgain_en),
    .word       (active_word),
    .fe_atten   (fe_atten),
    .ana_code   (ana_code),
    .dig_factor (dig_factor)
  );

  assign lane_in[0] = smp_i;
  assign lane_in[1] = smp_q;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    gsc_lane_scaler #(.SMP_W(SMP_W), .FACT_W(FACT_W), .FRAC_W(FRAC_W)) u_scale (
      .clk (clk),
      .rst (rst),
      .en  (smp_valid),
      .smp (lane_in[ln]),
      .fac (dig_factor),
      .res (lane_out[ln])
    );
  end

  assign out_i = lane_out[0];
  assign out_q = lane_out[1];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= smp_valid;
  end
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
  parameter int WORD_W   = 16,
  parameter int SMP_W    = 16,
  parameter int INTERVAL = 240
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_auto,
  input logic              dgain_en,
  input logic              apply,
  input logic              smp_valid,
  input logic [SMP_W-1:0]  smp_i,
  input logic              out_valid,
  input logic [SMP_W-1:0]  out_i,
  input logic              fe_atten,
  input logic [WORD_W-3:0] ana_code,
  input logic [WORD_W-1:0] dig_factor
);
  localparam int FRAC_W = WORD_W - 3;
  localparam int CNT_W  = $clog2(INTERVAL + 1);
  localparam logic [WORD_W-1:0] UNITY = WORD_W'(1) << FRAC_W;
  localparam logic [WORD_W-1:0] MAXF  = WORD_W'(1) << (FRAC_W + 2);

  logic [CNT_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)                            gap <= CNT_W'(INTERVAL);
    else if (apply)                     gap <= CNT_W'(1);
    else if (gap < CNT_W'(INTERVAL))    gap <= gap + 1'b1;
  end

  // R7
  apply_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    apply |-> (gap >= CNT_W'(INTERVAL)));

  // R10
  one_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (ana_code == '0) || (dig_factor == UNITY));

  // R5
  factor_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dig_factor >= UNITY) && (dig_factor <= MAXF));

  // R3
  unity_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dgain_en)) |-> (dig_factor == UNITY));

  // R6
  sign_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst)) |->
      ((out_i == '0) || (out_i[SMP_W-1] == $past(smp_i[SMP_W-1]))));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) &&
     !$past(apply, 1) && !$past(apply, 2) &&
     !$past(mode_auto, 1) && !$past(mode_auto, 2) &&
     ($past(dgain_en, 1) == $past(dgain_en, 2)))
    |-> ($stable(ana_code) && $stable(dig_factor) && $stable(fe_atten)));

  logic unused_ok;
  assign unused_ok = smp_valid;
endmodule

bind gain_split_ctrl gsc_checker #(
  .WORD_W(WORD_W), .SMP_W(SMP_W), .INTERVAL(INTERVAL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_auto  (mode_auto),
  .dgain_en   (dgain_en),
  .apply      (apply_w),
  .smp_valid  (smp_valid),
  .smp_i      (smp_i),
  .out_valid  (out_valid),
  .out_i      (out_i),
  .fe_atten   (fe_atten),
  .ana_code   (ana_code),
  .dig_factor (dig_factor)
);

// File: tb/gain_split_ctrl_test.sv
`timescale 1ns/1ps
module gain_split_ctrl_test;
  localparam int INTERVAL = 240;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_auto = 1'b0;
  logic        dgain_en = 1'b1;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_word = '0;
  logic [15:0] auto_word = '0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_i = '0;
  logic [15:0] smp_q = '0;
  logic        fe_atten;
  logic [13:0] ana_code;
  logic [15:0] dig_factor;
  logic        out_valid;
  logic [15:0] out_i;
  logic [15:0] out_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gain_split_ctrl uut (
    .clk(clk), .rst(rst), .mode_auto(mode_auto), .dgain_en(dgain_en),
    .wr_valid(wr_valid), .wr_word(wr_word), .auto_word(auto_word),
    .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .fe_atten(fe_atten), .ana_code(ana_code), .dig_factor(dig_factor),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_ana(input int w, input bit en);
    int fld = w & 32'h7FFF;
    if (!en) return w & 32'h3FFF;
    if (fld >= 16384) return fld - 16384;
    return 0;
  endfunction

  function automatic int m_fac(input int w, input bit en);
    int fld = w & 32'h7FFF;
    int g;
    if (!en || fld >= 16384) return 8192;
    g = 16384 - fld;
    return (8192 + (g % 8192)) * (1 << (g / 8192));
  endfunction

  function automatic int m_scale(input int s, input int f);
    longint v = longint'(s) * f + 4096;
    longint q;
    if (v >= 0) q = v / 8192;
    else        q = -((-v + 8191) / 8192);
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic chk_gain(input string req, input int w);
    chk({req, " fe"},  int'(fe_atten),   (w >> 15) & 1);
    chk({req, " ana"}, int'(ana_code),   m_ana(w, dgain_en));
    chk({req, " fac"}, int'(dig_factor), m_fac(w, dgain_en));
  endtask

  task automatic put_word(input logic [15:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_word = w;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic set_word(input logic [15:0] w);
    put_word(w);
    repeat (INTERVAL) @(negedge clk);
  endtask

  task automatic send_pair(input string req, input int si, input int sq);
    int f = int'(dig_factor);
    @(negedge clk); smp_valid = 1'b1; smp_i = 16'(si); smp_q = 16'(sq);
    @(negedge clk); smp_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " i"}, int'($signed(out_i)), m_scale(si, f));
    chk({req, " q"}, int'($signed(out_q)), m_scale(sq, f));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 fe", int'(fe_atten), 0);
    chk("R1 ana", int'(ana_code), 0);
    chk("R1 fac", int'(dig_factor), 8192);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 out", int'(out_i) + int'(out_q), 0);
    rst = 1'b0;
    repeat (INTERVAL) @(negedge clk);
  endtask

  task automatic t_front_flag;
    dgain_en = 1'b1;
    set_word(16'h8000); chk_gain("R2 R5", 16'h8000);
    dgain_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_gain("R2 off", 16'h8000);
    dgain_en = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_decode_off;
    dgain_en = 1'b0;
    set_word(16'h4123); chk_gain("R3 bit14", 16'h4123);
    chk("R3 ana", int'(ana_code), 16'h0123);
    set_word(16'h3FFF); chk_gain("R3 max", 16'h3FFF);
    dgain_en = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_decode_on;
    set_word(16'h7FFF); chk_gain("R4 top", 16'h7FFF);
    set_word(16'h4000); chk_gain("R4 mid", 16'h4000);
    set_word(16'h2000); chk_gain("R5 2x", 16'h2000);
    chk("R5 2x", int'(dig_factor), 16384);
    set_word(16'h1000); chk_gain("R5 3x", 16'h1000);
    set_word(16'h3FFF); chk_gain("R5 edge", 16'h3FFF);
  endtask

  task automatic t_scale;
    set_word(16'h0000);
    chk("R5 max", int'(dig_factor), 32768);
    send_pair("R6 clamp", 20000, -20000);
    chk("R6 clamp hi", int'($signed(out_i)), 32767);
    chk("R6 clamp lo", int'($signed(out_q)), -32768);
    @(negedge clk);
    chk("R6 idle", int'(out_valid), 0);
    set_word(16'h3000);
    chk("R6 f1.5", int'(dig_factor), 12288);
    send_pair("R6 round", 3, -3);
    chk("R6 round hi", int'($signed(out_i)), 5);
    chk("R6 round lo", int'($signed(out_q)), -4);
    set_word(16'h4000);
    send_pair("R6 unity", 1234, -1);
  endtask

  task automatic t_rate;
    set_word(16'h1234);
    put_word(16'h7FFF);          // applied: now 1 negedge after edge e0
    put_word(16'h8000);          // early, held
    chk_gain("R7 early held", 16'h7FFF);
    repeat (5) @(negedge clk);
    put_word(16'h1000);          // newer held write replaces previous
    repeat (INTERVAL - 9) @(negedge clk);
    chk_gain("R8 before R10", 16'h7FFF);
    @(negedge clk);
    chk_gain("R8 newest R10", 16'h1000);
    repeat (INTERVAL) @(negedge clk);
    chk_gain("R8 no replay", 16'h1000);
  endtask

  task automatic t_auto;
    @(negedge clk); mode_auto = 1'b1; auto_word = 16'hC123;
    @(negedge clk); @(negedge clk);
    chk_gain("R9 follow", 16'hC123);
    put_word(16'h0000);
    @(negedge clk);
    chk_gain("R9 write ignored", 16'hC123);
    auto_word = 16'h2000;
    @(negedge clk); @(negedge clk);
    chk_gain("R9 track", 16'h2000);
    put_word(16'h7FFF);
    mode_auto = 1'b0;
    repeat (INTERVAL + 5) @(negedge clk);
    chk_gain("R9 dropped", 16'h2000);
  endtask

  initial begin
    t_reset();
    t_front_flag();
    t_decode_off();
    t_decode_on();
    t_scale();
    t_rate();
    t_auto();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule